// File: doc/BRIEF.md
# Protected Tag Memory Access Controller

This block guards a small nonvolatile-style memory of 64 blocks. Each block holds 32 data bits and one lock bit, and is addressed by a 6-bit block number. Requests arrive one per cycle as a read or a write. A write stores the 32 data bits and the lock bit in one step. Once a block's lock bit is set, that block can never be written again, and this includes its lock bit.

The address space has four kinds of block:
- The low 32 blocks hold user data and are open without any login.
- Blocks 32 to 53 do not exist.
- Blocks 56 to 61 hold the tag identity and the factory traceability words. They are readable by anyone.
- Blocks 54, 55, 62 and 63 hold the read password, the write password, the protection settings and the configuration word. Reading them requires an active read session.

Writing any block from 54 to 63 requires an active write session. A separate login port compares a presented 32-bit value against the stored read or write password. A match opens the matching session and a mismatch closes it.

Each request or login produces exactly one result one cycle later. The result carries a grant flag and, for a granted read, the block's data and lock bit. Storage is a plain register array with reset values. Programming timing and the air interface belong to other blocks.

Top module: `protMemCtrl`

## Requirements
- R1: A request (reqValid=1) or a login (loginValid=1) sampled at a clock edge produces respValid=1 for exactly the following cycle. A cycle with neither produces respValid=0 in the following cycle.
- R2: Blocks 0 to 31 are read and written without login unless locked. A granted write stores the 32 data bits and reqLock together, and a later read returns both on rdData and rdLock.
- R3: A write to a block whose stored lock bit is 1 is denied (respOk=0), even when reqLock=0. The block's data and lock bit stay unchanged.
- R4: Every read or write to addresses 32 to 53 is denied.
- R5: After reset, blocks 59, 60 and 61 hold the value TRACE_SEED plus the block number, with lock bit 1. Writes to them are denied even during a write session.
- R6: Blocks 56 to 61 can be read without login. Reads of blocks 54, 55, 62 and 63 are granted only while a read session is open.
- R7: A write to any block from 54 to 63 is granted only while a write session is open and the block is unlocked.
- R8: A login with loginWrite=1 compares loginPass against block 55, and with loginWrite=0 against block 54. A match gives respOk=1 and opens that session. A mismatch gives respOk=0 and closes it. Reset closes both sessions and clears all non-traceability blocks to zero with lock bit 0.
- R9: On a denied request, on any write, and on any login result, rdData and rdLock are 0. A denied request changes no stored contents.
- R10: When reqValid and loginValid are both 1 in the same cycle, the login is ignored. The result belongs to the request, and neither session changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Access request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 6 | Block number |
| reqData | input | 32 | Write data |
| reqLock | input | 1 | Lock bit to program with the write |
| loginValid | input | 1 | Login attempt present |
| loginWrite | input | 1 | 1 = write password, 0 = read password |
| loginPass | input | 32 | Presented password |
| respValid | output | 1 | Result valid this cycle |
| respOk | output | 1 | 1 = granted or login matched |
| rdData | output | 32 | Data of a granted read, else 0 |
| rdLock | output | 1 | Lock bit of a granted read, else 0 |

## Verification
The access decision is tried with the same read and write patterns in every region of the map: user, unimplemented, open identity, traceability and guarded blocks. Each of these patterns is repeated before and after the write and read sessions open. A user block is first written with its lock bit set and then rewritten with the lock cleared, which separates lock enforcement from a plain overwrite. Login attempts include a wrong value, a right value, and a right value after the password block has been changed. This separates a comparison against stored contents from a fixed constant. A login issued together with a request, and a reset in the middle of a session, show that the session flags move only on a lone login.

// File: rtl/tmg_pkg.sv
package tmg_pkg;

  // Strobes from the control path to the storage path
  typedef struct packed {
    logic take;  // a result is produced this cycle
    logic wrEn;  // granted write
    logic rdEn;  // granted read
  } tmgStrobe_t;

  typedef enum logic [1:0] {
    ZONE_USER,   // free access subject to lock
    ZONE_VOID,   // unimplemented
    ZONE_OPEN,   // readable by anyone, written under write session
    ZONE_GUARD   // read session to read, write session to write
  } tmgZone_e;

endpackage

// File: rtl/tmgCtrl.sv
module tmgCtrl
  import tmg_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int USER_BLKS = 32,
  parameter int SYS_BASE  = 54,
  parameter int OPEN_LO   = 56,
  parameter int OPEN_HI   = 61
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              loginValid,
  input  logic              loginWrite,
  input  logic [DATA_W-1:0] loginPass,
  input  logic              blkLock,
  input  logic [DATA_W-1:0] readPw,
  input  logic [DATA_W-1:0] writePw,
  output tmgStrobe_t        stb,
  output logic              respValid,
  output logic              respOk
);

  localparam logic [ADDR_W-1:0] USER_LAST = ADDR_W'(USER_BLKS - 1);
  localparam logic [ADDR_W-1:0] SYS_FIRST = ADDR_W'(SYS_BASE);
  localparam logic [ADDR_W-1:0] OPEN_FIRST = ADDR_W'(OPEN_LO);
  localparam logic [ADDR_W-1:0] OPEN_LAST = ADDR_W'(OPEN_HI);

  logic     rdSess, wrSess;
  tmgZone_e zone;
  logic     allow;
  logic     pwMatch;
  logic     loneLogin;

  always_comb begin
    if (reqAddr <= USER_LAST)                              zone = ZONE_USER;
    else if (reqAddr < SYS_FIRST)                          zone = ZONE_VOID;
    else if (reqAddr >= OPEN_FIRST && reqAddr <= OPEN_LAST) zone = ZONE_OPEN;
    else                                                   zone = ZONE_GUARD;
  end

  always_comb begin
    unique case (zone)
      ZONE_USER:  allow = reqWrite ? !blkLock : 1'b1;
      ZONE_VOID:  allow = 1'b0;
      ZONE_OPEN:  allow = reqWrite ? (wrSess && !blkLock) : 1'b1;
      default:    allow = reqWrite ? (wrSess && !blkLock) : rdSess;
    endcase
  end

  assign pwMatch   = (loginPass == (loginWrite ? writePw : readPw));
  assign loneLogin = loginValid && !reqValid;

  always_comb begin
    stb.take = reqValid || loginValid;
    stb.wrEn = reqValid && reqWrite && allow;
    stb.rdEn = reqValid && !reqWrite && allow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdSess    <= 1'b0;
      wrSess    <= 1'b0;
      respValid <= 1'b0;
      respOk    <= 1'b0;
    end else begin
      respValid <= stb.take;
      respOk    <= reqValid ? allow : (loginValid && pwMatch);
      if (loneLogin) begin
        if (loginWrite) wrSess <= pwMatch;
        else            rdSess <= pwMatch;
      end
    end
  end

endmodule

// File: rtl/tmgStore.sv
module tmgStore
  import tmg_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter int          DATA_W     = 32,
  parameter int          TRACE_LO   = 59,
  parameter int          TRACE_HI   = 61,
  parameter int          RPW_BLK    = 54,
  parameter int          WPW_BLK    = 55,
  parameter logic [31:0] TRACE_SEED = 32'h5A17_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmgStrobe_t        stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              reqLock,
  output logic              blkLock,
  output logic [DATA_W-1:0] readPw,
  output logic [DATA_W-1:0] writePw,
  output logic [DATA_W-1:0] rdData,
  output logic              rdLock
);

  localparam int NUM_BLK = 1 << ADDR_W;

  logic [DATA_W-1:0] dataMem [NUM_BLK];
  logic              lockMem [NUM_BLK];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BLK; i++) begin
        if (i >= TRACE_LO && i <= TRACE_HI) begin
          dataMem[i] <= DATA_W'(TRACE_SEED) + DATA_W'(i);
          lockMem[i] <= 1'b1;
        end else begin
          dataMem[i] <= '0;
          lockMem[i] <= 1'b0;
        end
      end
    end else if (stb.wrEn) begin
      dataMem[reqAddr] <= reqData;
      lockMem[reqAddr] <= reqLock;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      rdLock <= 1'b0;
    end else if (stb.take) begin
      rdData <= stb.rdEn ? dataMem[reqAddr] : '0;
      rdLock <= stb.rdEn ? lockMem[reqAddr] : 1'b0;
    end
  end

  assign blkLock = lockMem[reqAddr];
  assign readPw  = dataMem[RPW_BLK];
  assign writePw = dataMem[WPW_BLK];

endmodule

// File: rtl/protMemCtrl.sv
module protMemCtrl
  import tmg_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter int          DATA_W     = 32,
  parameter int          USER_BLKS  = 32,
  parameter int          SYS_BASE   = 54,
  parameter int          OPEN_LO    = 56,
  parameter int          OPEN_HI    = 61,
  parameter int          TRACE_LO   = 59,
  parameter int          TRACE_HI   = 61,
  parameter int          RPW_BLK    = 54,
  parameter int          WPW_BLK    = 55,
  parameter logic [31:0] TRACE_SEED = 32'h5A17_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              reqLock,
  input  logic              loginValid,
  input  logic              loginWrite,
  input  logic [DATA_W-1:0] loginPass,
  output logic              respValid,
  output logic              respOk,
  output logic [DATA_W-1:0] rdData,
  output logic              rdLock
);

  tmgStrobe_t        stb;
  logic              blkLock;
  logic [DATA_W-1:0] readPw, writePw;

  tmgCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .USER_BLKS(USER_BLKS),
    .SYS_BASE(SYS_BASE), .OPEN_LO(OPEN_LO), .OPEN_HI(OPEN_HI)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .loginValid(loginValid), .loginWrite(loginWrite),
    .loginPass(loginPass), .blkLock(blkLock), .readPw(readPw),
    .writePw(writePw), .stb(stb), .respValid(respValid), .respOk(respOk)
  );

  tmgStore #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRACE_LO(TRACE_LO),
    .TRACE_HI(TRACE_HI), .RPW_BLK(RPW_BLK), .WPW_BLK(WPW_BLK),
    .TRACE_SEED(TRACE_SEED)
  ) i_store (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr),
    .reqData(reqData), .reqLock(reqLock), .blkLock(blkLock),
    .readPw(readPw), .writePw(writePw), .rdData(rdData), .rdLock(rdLock)
  );

endmodule

// File: rtl/tmgCheck.sv
module tmgCheck #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              loginValid,
  input logic              respValid,
  input logic              respOk,
  input logic [DATA_W-1:0] rdData,
  input logic              blkLock
);

  // R1: every request or login yields one result in the next cycle
  a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid || loginValid) |=> respValid);

  // R1: no stimulus, no result
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid || loginValid) |=> !respValid);

  // R3: a write aimed at a locked block is never granted
  a_r3_locked_write_denied: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && blkLock) |=> !respOk);

  // R4: unimplemented addresses are always refused
  a_r4_void_denied: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr >= ADDR_W'(32) && reqAddr <= ADDR_W'(53)) |=> !respOk);

  // R5: traceability blocks stay locked
  a_r5_trace_locked: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr >= ADDR_W'(59) && reqAddr <= ADDR_W'(61)) |-> blkLock);

  // R9: a refusal never exposes data
  a_r9_deny_zero: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respOk) |-> (rdData == '0));

endmodule

bind protMemCtrl tmgCheck #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tmgCheck (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .loginValid(loginValid), .respValid(respValid),
  .respOk(respOk), .rdData(rdData), .blkLock(blkLock)
);

// File: tb/test_protMemCtrl.sv
module test_protMemCtrl;

  localparam logic [31:0] SEED = 32'h5A17_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqLock = 1'b0;
  logic [5:0]  reqAddr = '0;
  logic [31:0] reqData = '0;
  logic        loginValid = 1'b0, loginWrite = 1'b0;
  logic [31:0] loginPass = '0;
  logic        respValid, respOk, rdLock;
  logic [31:0] rdData;

  int nTests = 0;
  int nFail  = 0;

  always #2 clk = ~clk;

  protMemCtrl i_protMemCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .reqLock(reqLock),
    .loginValid(loginValid), .loginWrite(loginWrite), .loginPass(loginPass),
    .respValid(respValid), .respOk(respOk), .rdData(rdData), .rdLock(rdLock)
  );

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request; result compared as {respValid, respOk, rdLock, rdData}
  task automatic access(input string tag, input logic wr, input logic [5:0] a,
                        input logic [31:0] d, input logic lk, input logic expOk,
                        input logic [31:0] expData, input logic expLock);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqData = d; reqLock = lk;
    @(posedge clk); #1;
    reqValid = 1'b0;
    check(tag, {1'b1, respValid, respOk, rdLock, rdData},
               {1'b1, 1'b1, expOk, expLock, expData});
  endtask

  task automatic login(input string tag, input logic wr, input logic [31:0] p,
                       input logic expOk);
    @(negedge clk);
    loginValid = 1'b1; loginWrite = wr; loginPass = p;
    @(posedge clk); #1;
    loginValid = 1'b0;
    check(tag, {1'b1, respValid, respOk, rdLock, rdData},
               {1'b1, 1'b1, expOk, 1'b0, 32'h0});
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic t_reset();
    #1;
    check("R1 reset respValid", {34'h0, respValid}, 35'h0);
    check("R9 reset rdData", {2'b0, rdLock, rdData}, 35'h0);
  endtask

  task automatic t_user();
    access("R2 write blk3", 1, 6'd3, 32'hA5A5_1234, 0, 1, 0, 0);
    access("R2 read blk3", 0, 6'd3, 0, 0, 1, 32'hA5A5_1234, 0);
    access("R2 write blk31", 1, 6'd31, 32'h0BAD_F00D, 0, 1, 0, 0);
    access("R2 read blk31", 0, 6'd31, 0, 0, 1, 32'h0BAD_F00D, 0);
    @(posedge clk); #1;
    check("R1 idle after access", {34'h0, respValid}, 35'h0);
  endtask

  task automatic t_lock();
    access("R2 write blk7 locked", 1, 6'd7, 32'hCAFE_0007, 1, 1, 0, 0);
    access("R3 read blk7 lock bit", 0, 6'd7, 0, 0, 1, 32'hCAFE_0007, 1);
    access("R3 rewrite clearing lock denied", 1, 6'd7, 32'h1111_1111, 0, 0, 0, 0);
    access("R3 blk7 unchanged", 0, 6'd7, 0, 0, 1, 32'hCAFE_0007, 1);
  endtask

  task automatic t_void();
    access("R4 read 32", 0, 6'd32, 0, 0, 0, 0, 0);
    access("R4 write 53", 1, 6'd53, 32'hFFFF_FFFF, 0, 0, 0, 0);
    access("R4 read 40", 0, 6'd40, 0, 0, 0, 0, 0);
  endtask

  task automatic t_open();
    access("R5 read trace 59", 0, 6'd59, 0, 0, 1, SEED + 32'd59, 1);
    access("R5 read trace 61", 0, 6'd61, 0, 0, 1, SEED + 32'd61, 1);
    access("R6 read id 56 free", 0, 6'd56, 0, 0, 1, 0, 0);
    access("R7 write 60 no session", 1, 6'd60, 32'h1, 0, 0, 0, 0);
    access("R7 write 57 no session", 1, 6'd57, 32'h1, 0, 0, 0, 0);
  endtask

  task automatic t_guard();
    access("R6 read 63 no session", 0, 6'd63, 0, 0, 0, 0, 0);
    access("R7 write 63 no session", 1, 6'd63, 32'h0000_C0F6, 0, 0, 0, 0);
    login("R8 wrong write pw", 1, 32'h1, 0);
    access("R8 write 63 still denied", 1, 6'd63, 32'h0000_C0F6, 0, 0, 0, 0);
    login("R8 right write pw", 1, 32'h0, 1);
    access("R7 write 63 session", 1, 6'd63, 32'h0000_C0F6, 0, 1, 0, 0);
    access("R5 write 60 session denied", 1, 6'd60, 32'h2, 0, 0, 0, 0);
    access("R5 trace 60 unchanged", 0, 6'd60, 0, 0, 1, SEED + 32'd60, 1);
    access("R6 read 63 needs read session", 0, 6'd63, 0, 0, 0, 0, 0);
    login("R8 right read pw", 0, 32'h0, 1);
    access("R6 read 63 session", 0, 6'd63, 0, 0, 1, 32'h0000_C0F6, 0);
    access("R7 set read pw blk54", 1, 6'd54, 32'h0000_1234, 0, 1, 0, 0);
    login("R8 old read pw fails", 0, 32'h0, 0);
    access("R8 mismatch closed read session", 0, 6'd63, 0, 0, 0, 0, 0);
    login("R8 new read pw", 0, 32'h0000_1234, 1);
    access("R8 read 63 reopened", 0, 6'd63, 0, 0, 1, 32'h0000_C0F6, 0);
  endtask

  task automatic t_simul();
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 6'd3;
    loginValid = 1'b1; loginWrite = 1'b0; loginPass = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    reqValid = 1'b0; loginValid = 1'b0;
    check("R10 request wins", {1'b0, respValid, respOk, rdLock, rdData},
          {1'b0, 1'b1, 1'b1, 1'b0, 32'hA5A5_1234});
    access("R10 read session kept", 0, 6'd63, 0, 0, 1, 32'h0000_C0F6, 0);
  endtask

  task automatic t_rst_sess();
    doReset();
    access("R8 reset closes read session", 0, 6'd63, 0, 0, 0, 0, 0);
    access("R8 reset closes write session", 1, 6'd62, 32'h5, 0, 0, 0, 0);
    access("R8 reset clears blk3", 0, 6'd3, 0, 0, 1, 0, 0);
    access("R8 reset unlocks blk7", 1, 6'd7, 32'h7, 0, 1, 0, 0);
    access("R5 trace after reset", 0, 6'd59, 0, 0, 1, SEED + 32'd59, 1);
  endtask

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rstN = 1'b1;
    t_user();
    t_lock();
    t_void();
    t_open();
    t_guard();
    t_simul();
    t_rst_sess();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule